// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a 32-bit processor core that completes one instruction per clock: in one cycle it fetches a word from its own instruction memory, decodes it, reads two registers, runs the ALU, optionally touches its own data memory, writes back and chooses the next program counter. It runs nine instructions: four arithmetic and logic operations, set-less-than, load word, store word, branch-if-equal and jump. Other encodings run as no-ops.

Both memories sit inside the core and are filled through a preload port while the core is held in reset. The program counter, register writes and data-memory stores are visible on trace outputs, so the embedding logic or a bench can follow execution without reaching into the block. Both memory depths are parameters. Each memory is indexed by the word address bits of a byte address, and wraps at its depth.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and no register or store write is signalled. After release the first instruction comes from byte address 0, and each instruction that is not a branch or jump advances pc_o by 4 on the next clock.
- R2: An instruction with opcode 0x00 (bits [31:26]) and funct (bits [5:0]) 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs AND rt or rs OR rt into the register named by bits [15:11]. rs is bits [25:21] and rt is bits [20:16].
- R3: Funct 0x2A writes 1 to the destination when rs is less than rt as signed two's complement values, and 0 otherwise (also 0 when they are equal).
- R4: Opcode 0x23 writes the data word at byte address rs + sign-extended bits [15:0] into the register named by rt (bits [20:16]).
- R5: Opcode 0x2B stores rt at byte address rs + sign-extended bits [15:0], shown on dm_we_o/dm_addr_o/dm_wdata_o, and writes no register.
- R6: Opcode 0x04 sets the next PC to PC+4 plus the sign-extended offset shifted left by 2 when rs equals rt, and to PC+4 otherwise. It writes neither a register nor memory.
- R7: Opcode 0x02 sets the next PC to bits [31:28] of PC+4, then instruction bits [25:0], then two zero bits.
- R8: Register 0 always reads as zero. A write to it is signalled but does not change it.
- R9: Any other opcode, and opcode 0x00 with any other funct, writes no register and no memory, and advances the PC by 4.
- R10: With ld_en_i high, ld_data_i is written at the next clock to the word selected by ld_addr_i bits [..:2]: instruction memory when ld_imem_i is 1, data memory when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_en_i | input | 1 | Preload write strobe |
| ld_imem_i | input | 1 | Preload target: 1 instruction memory, 0 data memory |
| ld_addr_i | input | 32 | Preload byte address |
| ld_data_i | input | 32 | Preload data word |
| pc_o | output | 32 | Address of the executing instruction |
| rf_we_o | output | 1 | Register write this cycle |
| rf_waddr_o | output | 5 | Destination register |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Store this cycle |
| dm_addr_o | output | 32 | ALU result, used as the memory byte address |
| dm_wdata_o | output | 32 | Store data |

## Verification
The bench builds the core with 64 instruction words and 16 data words. The 64 instruction words leave room for forward and backward branches and for a jump to byte address 64. The 16-word data memory keeps every positive and negative load/store offset in range, so store-then-load round trips show up directly in later write-back values. Register 0, unknown opcodes and unknown funct codes are checked through later instructions that read the registers they could have touched.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_CNT = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10,
    AOP_NONE  = 2'b11
  } alu_op_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_fn_e;

  typedef struct packed {
    logic    reg_write;
    logic    dst_rd;
    logic    alu_imm;
    logic    mem_write;
    logic    mem_to_reg;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o,
  output alu_fn_e    alu_fn_o
);
  ctrl_t main_c;
  logic  fn_ok;

  always_comb begin
    main_c        = '0;
    main_c.alu_op = AOP_ADD;
    case (opcode_i)
      OPC_RTYPE: begin
        main_c.reg_write = 1'b1;
        main_c.dst_rd    = 1'b1;
        main_c.alu_op    = AOP_FUNCT;
      end
      OPC_LW: begin
        main_c.reg_write  = 1'b1;
        main_c.alu_imm    = 1'b1;
        main_c.mem_to_reg = 1'b1;
      end
      OPC_SW: begin
        main_c.alu_imm   = 1'b1;
        main_c.mem_write = 1'b1;
      end
      OPC_BEQ: begin
        main_c.branch = 1'b1;
        main_c.alu_op = AOP_SUB;
      end
      OPC_J: begin
        main_c.jump   = 1'b1;
        main_c.alu_op = AOP_NONE;
      end
      default: main_c.alu_op = AOP_NONE;
    endcase
  end

  always_comb begin
    alu_fn_o = ALU_ADD;
    fn_ok    = 1'b1;
    case (main_c.alu_op)
      AOP_ADD: alu_fn_o = ALU_ADD;
      AOP_SUB: alu_fn_o = ALU_SUB;
      AOP_FUNCT: begin
        case (funct_i)
          FN_ADD:  alu_fn_o = ALU_ADD;
          FN_SUB:  alu_fn_o = ALU_SUB;
          FN_AND:  alu_fn_o = ALU_AND;
          FN_OR:   alu_fn_o = ALU_OR;
          FN_SLT:  alu_fn_o = ALU_SLT;
          default: fn_ok    = 1'b0;
        endcase
      end
      default: alu_fn_o = ALU_ADD;
    endcase
  end

  // unknown funct degrades to a no-op
  always_comb begin
    ctrl_o           = main_c;
    ctrl_o.reg_write = main_c.reg_write & fn_ok;
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    case (fn_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = '0;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [N-1:0][W-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '0;
    else if (we_i && waddr_i != '0) regs_q[waddr_i] <= wdata_i;
  end

  // entry 0 is hard zero on read
  assign rdata_a_o = (raddr_a_i == '0) ? '0 : regs_q[raddr_a_i];
  assign rdata_b_o = (raddr_b_i == '0) ? '0 : regs_q[raddr_b_i];
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int W     = 32,
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sc_next_pc.sv
module sc_next_pc
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] off_i,
  input  logic [25:0]     tgt_i,
  input  logic            br_take_i,
  input  logic            jump_i,
  output logic [XLEN-1:0] pc_next_o
);
  logic [XLEN-1:0] pc_inc;
  logic [XLEN-1:0] br_dst;
  logic [XLEN-1:0] j_dst;

  assign pc_inc = pc_i + XLEN'(4);
  assign br_dst = pc_inc + {off_i[XLEN-3:0], 2'b00};
  assign j_dst  = {pc_inc[XLEN-1:XLEN-4], tgt_i, 2'b00};

  always_comb begin
    if (jump_i)         pc_next_o = j_dst;
    else if (br_take_i) pc_next_o = br_dst;
    else                pc_next_o = pc_inc;
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_en_i,
  input  logic              ld_imem_i,
  input  logic [XLEN-1:0]   ld_addr_i,
  input  logic [XLEN-1:0]   ld_data_i,
  output logic [XLEN-1:0]   pc_o,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              dm_we_o,
  output logic [XLEN-1:0]   dm_addr_o,
  output logic [XLEN-1:0]   dm_wdata_o
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0]   pc_q, pc_d;
  logic [XLEN-1:0]   instr;
  ctrl_t             ctrl;
  alu_fn_e           alu_fn;
  logic [REG_AW-1:0] rs, rt, rd, dst;
  logic [XLEN-1:0]   rs_val, rt_val, imm_sx, alu_b, alu_y, dm_rdata, wb_data;
  logic              alu_zero, rf_we, st_we;
  logic              dm_wr;
  logic [DAW-1:0]    dm_widx;
  logic [XLEN-1:0]   dm_wval;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  sc_mem #(.W(XLEN), .WORDS(IMEM_WORDS)) u_imem (
    .clk_i   (clk_i),
    .we_i    (ld_en_i & ld_imem_i),
    .waddr_i (ld_addr_i[IAW+1:2]),
    .wdata_i (ld_data_i),
    .raddr_i (pc_q[IAW+1:2]),
    .rdata_o (instr)
  );

  assign rs = instr[25:21];
  assign rt = instr[20:16];
  assign rd = instr[15:11];
  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_decoder u_dec (
    .opcode_i (instr[31:26]),
    .funct_i  (instr[5:0]),
    .ctrl_o   (ctrl),
    .alu_fn_o (alu_fn)
  );

  assign dst   = ctrl.dst_rd ? rd : rt;
  assign rf_we = ctrl.reg_write & rst_ni;

  sc_regfile #(.W(XLEN), .N(REG_CNT)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (dst),
    .wdata_i   (wb_data),
    .raddr_a_i (rs),
    .raddr_b_i (rt),
    .rdata_a_o (rs_val),
    .rdata_b_o (rt_val)
  );

  assign alu_b = ctrl.alu_imm ? imm_sx : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .fn_i   (alu_fn),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  // preload port owns the data-memory write path while strobed
  assign st_we   = ctrl.mem_write & rst_ni;
  assign dm_wr   = (ld_en_i & ~ld_imem_i) | st_we;
  assign dm_widx = ld_en_i ? ld_addr_i[DAW+1:2] : alu_y[DAW+1:2];
  assign dm_wval = ld_en_i ? ld_data_i : rt_val;

  sc_mem #(.W(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (dm_wr),
    .waddr_i (dm_widx),
    .wdata_i (dm_wval),
    .raddr_i (alu_y[DAW+1:2]),
    .rdata_o (dm_rdata)
  );

  assign wb_data = ctrl.mem_to_reg ? dm_rdata : alu_y;

  sc_next_pc u_npc (
    .pc_i      (pc_q),
    .off_i     (imm_sx),
    .tgt_i     (instr[25:0]),
    .br_take_i (ctrl.branch & alu_zero),
    .jump_i    (ctrl.jump),
    .pc_next_o (pc_d)
  );

  assign pc_o       = pc_q;
  assign rf_we_o    = rf_we;
  assign rf_waddr_o = dst;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = st_we;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

  logic unused_bits;
  assign unused_bits = ^{ld_addr_i[XLEN-1:IAW+2], ld_addr_i[XLEN-1:DAW+2], ld_addr_i[1:0]};
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [XLEN-1:0]   pc_i,
  input logic [XLEN-1:0]   instr_i,
  input logic              rf_we_i,
  input logic [REG_AW-1:0] rf_waddr_i,
  input logic              dm_we_i
);
  logic [5:0] opc;
  logic [5:0] fn;
  logic       known_op, known_fn;

  assign opc      = instr_i[31:26];
  assign fn       = instr_i[5:0];
  assign known_op = (opc == OPC_RTYPE) || (opc == OPC_LW) || (opc == OPC_SW) ||
                    (opc == OPC_BEQ) || (opc == OPC_J);
  assign known_fn = (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) ||
                    (fn == FN_OR) || (fn == FN_SLT);

  // R1
  reset_pc_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_i == '0 && !rf_we_i && !dm_we_i));

  // R1
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc != OPC_BEQ && opc != OPC_J) |=> pc_i == $past(pc_i) + 32'd4);

  // R2
  rtype_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc == OPC_RTYPE && rf_we_i) |-> rf_waddr_i == instr_i[15:11]);

  // R4
  load_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc == OPC_LW) |-> (rf_we_i && rf_waddr_i == instr_i[20:16] && !dm_we_i));

  // R5
  store_no_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_we_i |-> (!rf_we_i && opc == OPC_SW));

  // R6
  beq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc == OPC_BEQ) |-> (!rf_we_i && !dm_we_i));

  // R9
  unknown_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!known_op || (opc == OPC_RTYPE && !known_fn)) |-> (!rf_we_i && !dm_we_i));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_i       (pc_o),
  .instr_i    (instr),
  .rf_we_i    (rf_we_o),
  .rf_waddr_i (rf_waddr_o),
  .dm_we_i    (dm_we_o)
);

// File: tb/sc_core_test.sv
module sc_core_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        ld_en_i = 1'b0;
  logic        ld_imem_i = 1'b0;
  logic [31:0] ld_addr_i = '0;
  logic [31:0] ld_data_i = '0;
  logic [31:0] pc_o;
  logic        rf_we_o;
  logic [4:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o;
  logic        dm_we_o;
  logic [31:0] dm_addr_o;
  logic [31:0] dm_wdata_o;

  int n_chk = 0;
  int n_bad = 0;

  sc_core #(.IMEM_WORDS(64), .DMEM_WORDS(16)) uut (
    .clk_i, .rst_ni, .ld_en_i, .ld_imem_i, .ld_addr_i, .ld_data_i,
    .pc_o, .rf_we_o, .rf_waddr_o, .rf_wdata_o, .dm_we_o, .dm_addr_o, .dm_wdata_o
  );

  always #5 clk_i = ~clk_i;

  function automatic logic [31:0] r_ins(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_ins(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] j_ins(input logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  task automatic ck(input string rq, input string what, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  // R10: preload one word
  task automatic ld(input logic im, input int widx, input logic [31:0] d);
    ld_imem_i = im;
    ld_addr_i = 32'(widx * 4);
    ld_data_i = d;
    ld_en_i   = 1'b1;
    step();
    ld_en_i   = 1'b0;
  endtask

  task automatic hold();
    rst_ni = 1'b0;
    #1;
  endtask

  task automatic go();
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic exp_rf(input string rq, input logic [31:0] pc, input logic [4:0] wa,
                        input logic [31:0] wd);
    ck(rq, "pc", pc_o, pc);
    ck(rq, "rf_we", 32'(rf_we_o), 32'd1);
    ck(rq, "waddr", 32'(rf_waddr_o), 32'(wa));
    ck(rq, "wdata", rf_wdata_o, wd);
    ck(rq, "dm_we", 32'(dm_we_o), 32'd0);
  endtask

  task automatic exp_st(input string rq, input logic [31:0] pc, input logic [31:0] a, d);
    ck(rq, "pc", pc_o, pc);
    ck(rq, "dm_we", 32'(dm_we_o), 32'd1);
    ck(rq, "rf_we", 32'(rf_we_o), 32'd0);
    ck(rq, "dm_addr", dm_addr_o, a);
    ck(rq, "dm_wdata", dm_wdata_o, d);
  endtask

  task automatic exp_none(input string rq, input logic [31:0] pc);
    ck(rq, "pc", pc_o, pc);
    ck(rq, "rf_we", 32'(rf_we_o), 32'd0);
    ck(rq, "dm_we", 32'(dm_we_o), 32'd0);
  endtask

  task automatic t_reset();
    hold();
    ld(1'b1, 0, r_ins(5'd0, 5'd0, 5'd1, 6'h20));
    ld(1'b1, 1, r_ins(5'd0, 5'd0, 5'd2, 6'h20));
    ld(1'b1, 2, r_ins(5'd0, 5'd0, 5'd3, 6'h20));
    exp_none("R1", 32'd0);
    step();
    exp_none("R1", 32'd0);
    go();
    ck("R1", "pc", pc_o, 32'd0);
    step();
    ck("R1", "pc", pc_o, 32'd4);
    step();
    ck("R1", "pc", pc_o, 32'd8);
    rst_ni = 1'b0;
    #1;
    exp_none("R1", 32'd0);
  endtask

  task automatic t_alu();
    hold();
    ld(1'b0, 0, 32'h0000_00F0);
    ld(1'b0, 1, 32'hFFFF_FFF6);
    ld(1'b0, 2, 32'd8);
    ld(1'b1, 0, i_ins(6'h23, 5'd0, 5'd1, 16'd0));
    ld(1'b1, 1, i_ins(6'h23, 5'd0, 5'd2, 16'd4));
    ld(1'b1, 2, i_ins(6'h23, 5'd0, 5'd3, 16'd8));
    ld(1'b1, 3, r_ins(5'd1, 5'd3, 5'd4, 6'h20));
    ld(1'b1, 4, r_ins(5'd3, 5'd2, 5'd5, 6'h22));
    ld(1'b1, 5, r_ins(5'd1, 5'd2, 5'd6, 6'h24));
    ld(1'b1, 6, r_ins(5'd3, 5'd2, 5'd7, 6'h25));
    ld(1'b1, 7, r_ins(5'd2, 5'd3, 5'd8, 6'h2A));
    ld(1'b1, 8, r_ins(5'd3, 5'd2, 5'd9, 6'h2A));
    ld(1'b1, 9, r_ins(5'd3, 5'd3, 5'd10, 6'h2A));
    go();
    exp_rf("R4", 32'd0, 5'd1, 32'h0000_00F0); step();
    exp_rf("R4", 32'd4, 5'd2, 32'hFFFF_FFF6); step();
    exp_rf("R4", 32'd8, 5'd3, 32'd8); step();
    exp_rf("R2", 32'd12, 5'd4, 32'h0000_00F8); step();
    exp_rf("R2", 32'd16, 5'd5, 32'd18); step();
    exp_rf("R2", 32'd20, 5'd6, 32'h0000_00F0); step();
    exp_rf("R2", 32'd24, 5'd7, 32'hFFFF_FFFE); step();
    exp_rf("R3", 32'd28, 5'd8, 32'd1); step();
    exp_rf("R3", 32'd32, 5'd9, 32'd0); step();
    exp_rf("R3", 32'd36, 5'd10, 32'd0);
  endtask

  task automatic t_mem();
    hold();
    ld(1'b0, 0, 32'h1234_5678);
    ld(1'b0, 1, 32'hA5A5_A5A5);
    ld(1'b0, 3, 32'h0000_0020);
    ld(1'b1, 0, i_ins(6'h23, 5'd0, 5'd1, 16'd0));
    ld(1'b1, 1, i_ins(6'h23, 5'd0, 5'd2, 16'd12));
    ld(1'b1, 2, i_ins(6'h2B, 5'd2, 5'd1, 16'hFFF8));
    ld(1'b1, 3, i_ins(6'h23, 5'd0, 5'd3, 16'd24));
    ld(1'b1, 4, i_ins(6'h2B, 5'd2, 5'd2, 16'd4));
    ld(1'b1, 5, i_ins(6'h23, 5'd2, 5'd4, 16'hFFE4));
    ld(1'b1, 6, i_ins(6'h23, 5'd0, 5'd5, 16'd36));
    go();
    exp_rf("R4", 32'd0, 5'd1, 32'h1234_5678); step();
    exp_rf("R4", 32'd4, 5'd2, 32'h0000_0020); step();
    exp_st("R5", 32'd8, 32'h0000_0018, 32'h1234_5678); step();
    exp_rf("R5", 32'd12, 5'd3, 32'h1234_5678); step();
    exp_st("R5", 32'd16, 32'h0000_0024, 32'h0000_0020); step();
    exp_rf("R4", 32'd20, 5'd4, 32'hA5A5_A5A5); step();
    exp_rf("R5", 32'd24, 5'd5, 32'h0000_0020);
  endtask

  task automatic t_flow();
    hold();
    ld(1'b0, 0, 32'd5);
    ld(1'b0, 1, 32'd5);
    ld(1'b0, 2, 32'd9);
    ld(1'b1, 0, i_ins(6'h23, 5'd0, 5'd1, 16'd0));
    ld(1'b1, 1, i_ins(6'h23, 5'd0, 5'd2, 16'd4));
    ld(1'b1, 2, i_ins(6'h23, 5'd0, 5'd3, 16'd8));
    ld(1'b1, 3, i_ins(6'h04, 5'd1, 5'd3, 16'd5));
    ld(1'b1, 4, i_ins(6'h04, 5'd1, 5'd2, 16'd3));
    ld(1'b1, 8, i_ins(6'h04, 5'd0, 5'd0, 16'hFFFD));
    ld(1'b1, 6, j_ins(26'd16));
    ld(1'b1, 16, i_ins(6'h04, 5'd0, 5'd0, 16'hFFFF));
    go();
    step(); step(); step();
    exp_none("R6", 32'd12); step();
    exp_none("R6", 32'd16); step();
    exp_none("R6", 32'd32); step();
    exp_none("R7", 32'd24); step();
    exp_none("R7", 32'd64); step();
    exp_none("R6", 32'd64); step();
    ck("R6", "pc", pc_o, 32'd64);
  endtask

  task automatic t_zero_unknown();
    hold();
    ld(1'b0, 0, 32'h0000_0077);
    ld(1'b1, 0, i_ins(6'h23, 5'd0, 5'd1, 16'd0));
    ld(1'b1, 1, r_ins(5'd1, 5'd1, 5'd0, 6'h20));
    ld(1'b1, 2, i_ins(6'h2B, 5'd0, 5'd0, 16'd4));
    ld(1'b1, 3, i_ins(6'h23, 5'd0, 5'd0, 16'd0));
    ld(1'b1, 4, r_ins(5'd0, 5'd1, 5'd2, 6'h20));
    ld(1'b1, 5, i_ins(6'h3F, 5'd1, 5'd1, 16'h0004));
    ld(1'b1, 6, r_ins(5'd1, 5'd1, 5'd5, 6'h00));
    ld(1'b1, 7, i_ins(6'h08, 5'd1, 5'd6, 16'h0001));
    ld(1'b1, 8, r_ins(5'd1, 5'd0, 5'd7, 6'h25));
    go();
    step();
    exp_rf("R8", 32'd4, 5'd0, 32'h0000_00EE); step();
    exp_st("R8", 32'd8, 32'd4, 32'd0); step();
    exp_rf("R8", 32'd12, 5'd0, 32'h0000_0077); step();
    exp_rf("R8", 32'd16, 5'd2, 32'h0000_0077); step();
    exp_none("R9", 32'd20); step();
    exp_none("R9", 32'd24); step();
    exp_none("R9", 32'd28); step();
    exp_rf("R9", 32'd32, 5'd7, 32'h0000_0077);
  endtask

  initial begin
    #1;
    t_reset();
    t_alu();
    t_mem();
    t_flow();
    t_zero_unknown();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule